// File: doc/BRIEF.md
# Free-Running Timer Counter with Aliased Views

This block is a 16-bit up-counter that runs without stopping and is read by an 8-bit processor through byte registers. Two register pairs show the same count: a main pair and an alternate pair. The difference between them is in their side effects. A read sequence through the main pair can clear the overflow flag. The alternate pair never clears it, so a monitoring routine can sample the time without taking an overflow event away from the routine that handles it.

The count never loads any value other than FFFCh. Reset loads FFFCh, and so does any processor write to either low byte. A 2-bit rate input sets the pace. Three codes step the counter once every 2, 4 or 8 processor clocks. The fourth code steps it on each rising edge of an external clock input, after that input passes a two-flop synchroniser. When the count wraps from FFFFh to 0000h, the block sets a flag in a status register.

The register strobes carry no data, because every write to this block either reloads the count or has no effect.

Top module: `ftc_timer`

## Requirements
- R1: While reset is held, and at its release, the count is FFFCh and the overflow flag is 0.
- R2: A write strobe to address 1 (main low byte) or address 3 (alternate low byte) sets the count to FFFCh at that clock edge. It also restarts the internal divider, so the next internal step falls a full divide period later.
- R3: With rate code 00, 01 or 10, the count steps by one on every 2nd, 4th or 8th clock respectively. The full sequence therefore repeats every 131072, 262144 or 524288 clocks.
- R4: With rate code 11, the count steps once for each rising edge of ext_clk_i. An edge that arrives before clock edge n appears in the count after clock edge n+2. A level held high or low adds no further steps, and the internal divider has no effect in this mode.
- R5: The read address map is: 0 = main high byte, 1 = main low byte, 2 = alternate high byte, 3 = alternate low byte, 4 = status, with the overflow flag in bit 7 and the other bits 0. Addresses 5 to 7 read 00h. rdata_o is valid in the same cycle as rd_en_i, and it is 00h when rd_en_i is low.
- R6: A read of either high byte captures the low byte of the count at that edge. The next read of either low byte returns the captured byte. A low-byte read with no capture pending returns the live low byte.
- R7: When the count wraps from FFFFh to 0000h, the overflow flag is set at that clock edge. The flag is visible on ovf_flag_o and in status bit 7.
- R8: The flag clears only when a status read that sees the flag set is followed later by a read of the main low byte. A main low-byte read with no such earlier status read leaves the flag set. A wrap in the same cycle wins over a clear.
- R9: A read of the alternate low byte never clears the overflow flag.
- R10: Write strobes to addresses 0, 2, 4, 5, 6 and 7 change neither the count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 2 | Count rate: 00 /2, 01 /4, 10 /8, 11 external edges |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| addr_i | input | 3 | Register address |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rdata_o | output | 8 | Read data, combinational from address |
| ovf_flag_o | output | 1 | Overflow flag |

## Verification
The assertions assume that rd_en_i and wr_en_i are never high in the same cycle. They also assume that rate_sel_i changes only between accesses, so no tick happens while the divider is being re-selected. The stimulus reads one register per clock and writes one register per clock, never both at once. It changes the rate code only just before a reload write, which restarts the divider, and it moves ext_clk_i only at falling edges, with gaps that are longer than the synchroniser depth.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int PRE_W   = 3;   // log2 of the largest internal divide
  localparam int SYNC_N  = 2;
  localparam logic [CNT_W-1:0] RELOAD_VAL = 16'hFFFC;

  typedef enum logic [1:0] {
    RATE_DIV2 = 2'b00,
    RATE_DIV4 = 2'b01,
    RATE_DIV8 = 2'b10,
    RATE_EXT  = 2'b11
  } rate_e;

  typedef enum logic [2:0] {
    A_MAIN_HI = 3'd0,
    A_MAIN_LO = 3'd1,
    A_ALT_HI  = 3'd2,
    A_ALT_LO  = 3'd3,
    A_STAT    = 3'd4
  } addr_e;
endpackage

// File: rtl/ftc_prescaler.sv
module ftc_prescaler
  import ftc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] rate_sel_i,
  input  logic       ext_clk_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [SYNC_N:0]  sync_q;   // SYNC_N sync flops plus one edge-history flop
  logic             ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-1:0], ext_clk_i};
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  always_comb begin
    unique case (rate_e'(rate_sel_i))
      RATE_DIV2: tick_o = pre_q[0];
      RATE_DIV4: tick_o = &pre_q[1:0];
      RATE_DIV8: tick_o = &pre_q[2:0];
      default:   tick_o = ext_rise;
    endcase
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i != RATE_EXT && tick_o) |=> (!tick_o || rate_sel_i == RATE_EXT)); // R3
  AST_EXT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == RATE_EXT && tick_o) |=> (!tick_o || rate_sel_i != RATE_EXT)); // R4
endmodule

// File: rtl/ftc_counter.sv
module ftc_counter
  import ftc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RELOAD_VAL;
    else if (load_i) cnt_q <= RELOAD_VAL;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & ~load_i & (&cnt_q);

  AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == RELOAD_VAL); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q)); // R3
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3
endmodule

// File: rtl/ftc_regif.sv
module ftc_regif
  import ftc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              load_o,
  output logic              flag_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic              rd_hi, rd_lo, rd_main_lo, rd_stat;
  logic [BYTE_W-1:0] lo_hold_q;
  logic              hold_vld_q;
  logic              flag_q, arm_q;

  assign rd_hi      = rd_en_i & (addr_i == A_MAIN_HI || addr_i == A_ALT_HI);
  assign rd_lo      = rd_en_i & (addr_i == A_MAIN_LO || addr_i == A_ALT_LO);
  assign rd_main_lo = rd_en_i & (addr_i == A_MAIN_LO);
  assign rd_stat    = rd_en_i & (addr_i == A_STAT);
  assign load_o     = wr_en_i & (addr_i == A_MAIN_LO || addr_i == A_ALT_LO);

  // one capture slot shared by both views
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_hold_q  <= '0;
      hold_vld_q <= 1'b0;
    end else if (rd_hi) begin
      lo_hold_q  <= cnt_i[BYTE_W-1:0];
      hold_vld_q <= 1'b1;
    end else if (rd_lo) begin
      hold_vld_q <= 1'b0;
    end
  end

  // set wins over the two-step clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (wrap_i) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (rd_main_lo && arm_q) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (rd_stat && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_MAIN_HI, A_ALT_HI: rdata_o = cnt_i[CNT_W-1:BYTE_W];
        A_MAIN_LO, A_ALT_LO: rdata_o = hold_vld_q ? lo_hold_q : cnt_i[BYTE_W-1:0];
        A_STAT:              rdata_o = {flag_q, {(BYTE_W-1){1'b0}}};
        default:             rdata_o = '0;
      endcase
    end
  end

  assign flag_o = flag_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q); // R7
  AST_FLAG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !rd_main_lo) |=> flag_q); // R9
  AST_CLR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && rd_main_lo && !arm_q) |=> flag_q); // R8
  AST_NO_RW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && wr_en_i)); // R5
endmodule

// File: rtl/ftc_timer.sv
module ftc_timer
  import ftc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rate_sel_i,
  input  logic              ext_clk_i,
  input  logic [2:0]        addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              ovf_flag_o
);
  logic             load, tick, wrap;
  logic [CNT_W-1:0] cnt;

  ftc_prescaler u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (load),
    .rate_sel_i (rate_sel_i),
    .ext_clk_i  (ext_clk_i),
    .tick_o     (tick)
  );

  ftc_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .tick_i (tick),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  ftc_regif u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .cnt_i   (cnt),
    .wrap_i  (wrap),
    .load_o  (load),
    .flag_o  (ovf_flag_o),
    .rdata_o (rdata_o)
  );

  AST_RESET_FLAG: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !ovf_flag_o); // R1
endmodule

// File: tb/ftc_timer_test.sv
`timescale 1ns/1ps
module ftc_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       ext = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] rdata;
  logic       ovf;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ftc_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(rate), .ext_clk_i(ext),
    .addr_i(addr), .rd_en_i(rd), .wr_en_i(wr), .rdata_o(rdata), .ovf_flag_o(ovf)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a);
    addr = a; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 flag", {7'b0, ovf}, 8'h00);
    rd_reg(3'd2, d); check("R1 hi", d, 8'hFF);
    rd_reg(3'd3, d); check("R1 lo", d, 8'hFC);
    rd_reg(3'd4, d); check("R5 stat", d, 8'h00);
    rd_reg(3'd6, d); check("R5 unused addr", d, 8'h00);
  endtask

  task automatic t_div2_coherent();
    logic [7:0] d;
    rate = 2'b00;
    wr_reg(3'd1);
    idle(5);
    rd_reg(3'd0, d); check("R3 div2 hi", d, 8'hFF);
    rd_reg(3'd1, d); check("R6 latched lo", d, 8'hFE);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    rate = 2'b00;
    wr_reg(3'd3);
    idle(7);
    check("R7 before wrap", {7'b0, ovf}, 8'h00);
    idle(1);
    check("R7 wrap sets", {7'b0, ovf}, 8'h01);
    rd_reg(3'd3, d); check("R6 live lo", d, 8'h00);
    check("R9 alt lo keeps", {7'b0, ovf}, 8'h01);
    rd_reg(3'd4, d); check("R7 stat bit7", d, 8'h80);
    rd_reg(3'd3, d);
    check("R9 alt lo after stat keeps", {7'b0, ovf}, 8'h01);
    rd_reg(3'd4, d); check("R9 stat still set", d, 8'h80);
    rd_reg(3'd1, d);
    check("R8 cleared", {7'b0, ovf}, 8'h00);
    rd_reg(3'd4, d); check("R8 stat clear", d, 8'h00);
    wr_reg(3'd1);
    idle(8);
    check("R7 wrap again", {7'b0, ovf}, 8'h01);
    rd_reg(3'd1, d);
    check("R8 no arm keeps", {7'b0, ovf}, 8'h01);
    rd_reg(3'd4, d);
    rd_reg(3'd1, d);
    check("R8 armed clears", {7'b0, ovf}, 8'h00);
  endtask

  task automatic t_rates();
    logic [7:0] d;
    rate = 2'b01;
    wr_reg(3'd1);
    idle(12);
    rd_reg(3'd0, d); check("R3 div4 hi", d, 8'hFF);
    rd_reg(3'd1, d); check("R3 div4 lo", d, 8'hFF);
    rate = 2'b10;
    wr_reg(3'd3);
    idle(17);
    rd_reg(3'd2, d); check("R3 div8 hi", d, 8'hFF);
    rd_reg(3'd3, d); check("R3 div8 lo", d, 8'hFE);
  endtask

  task automatic t_external();
    logic [7:0] d;
    rate = 2'b11;
    wr_reg(3'd1);
    idle(6);
    rd_reg(3'd3, d); check("R4 no edges", d, 8'hFC);
    ext = 1'b1;
    idle(2);
    rd_reg(3'd3, d); check("R4 sync delay", d, 8'hFC);
    rd_reg(3'd3, d); check("R4 first edge", d, 8'hFD);
    idle(5);
    rd_reg(3'd3, d); check("R4 level held", d, 8'hFD);
    ext = 1'b0;
    idle(3);
    ext = 1'b1;
    idle(3);
    rd_reg(3'd3, d); check("R4 second edge", d, 8'hFE);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] d;
    wr_reg(3'd0);
    wr_reg(3'd2);
    wr_reg(3'd4);
    wr_reg(3'd5);
    wr_reg(3'd7);
    rd_reg(3'd0, d); check("R10 hi kept", d, 8'hFF);
    rd_reg(3'd1, d); check("R10 lo kept", d, 8'hFE);
    rd_reg(3'd4, d); check("R10 stat kept", d, 8'h00);
    wr_reg(3'd3);
    rd_reg(3'd1, d); check("R2 alt lo reload", d, 8'hFC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_div2_coherent();
    t_overflow();
    t_rates();
    t_external();
    t_ignored_writes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule